// File: doc/BRIEF.md
# Compare-and-Flag Execution Unit

This unit executes the 32-bit compare of a small accumulator processor. Each cycle it may receive an accumulator value, a memory operand that an earlier stage has already fetched, and a 16-bit instruction word. When the word is a compare and the issue strobe is high, the unit forms accumulator minus operand only to set the negative, zero and carry status flags. It writes nothing back to the accumulator or to memory.

It also registers an unsigned "higher" condition that a following conditional move can test. Because a compare cannot be repeated, it cancels any pending repeat count. The overflow flag is kept in the same status register but has its own write path, and a compare never changes it. Addressing-mode decode and operand fetch happen before this unit.

Top module: `cmp_flag_unit`

## Requirements
- R1: A compare is recognised only when `issue_valid` is high and bits [15:8] of `instr_word` equal 0x0F; bits [7:0] (the addressing-mode field) have no effect on the result.
- R2: `flag_n` is set when the mathematically exact signed difference accumulator − operand is negative, with no wrap at 32 bits (0x8000_0000 − 0x0000_0001 sets it), and is cleared otherwise.
- R3: `flag_z` is set when accumulator equals operand and is cleared otherwise.
- R4: `flag_c` is cleared when the unsigned subtraction borrows (accumulator < operand unsigned) and is set otherwise.
- R5: `cond_hi` equals `flag_c` AND NOT `flag_z` of the same compare, i.e. accumulator > operand unsigned.
- R6: A compare issued in cycle t shows its flags, and `cmp_done` high for exactly one cycle, after the clock edge that ends cycle t.
- R7: In any cycle without a recognised compare, N, Z, C and `cond_hi` keep their values and `cmp_done` is low.
- R8: A compare never changes `flag_v`; `flag_v` changes only through `ovf_wr`/`ovf_wdata`, one cycle after the write.
- R9: A recognised compare clears the repeat count to zero, and takes precedence over a load in the same cycle; otherwise `rpt_load` loads `rpt_value` and the count holds when neither occurs.
- R10: `acc_we` and `mem_we` stay low at all times.
- R11: Synchronous active-high `rst` clears all flags, `cond_hi`, `cmp_done` and the repeat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction issue strobe |
| instr_word | input | 16 | Decoded instruction word |
| acc_val | input | 32 | Accumulator value |
| opnd_val | input | 32 | Memory operand, already fetched |
| ovf_wr | input | 1 | Overflow flag write strobe |
| ovf_wdata | input | 1 | Overflow flag write value |
| rpt_load | input | 1 | Load the repeat counter |
| rpt_value | input | 8 | Repeat count to load |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry (no-borrow) flag |
| flag_v | output | 1 | Overflow flag |
| cond_hi | output | 1 | Unsigned greater-than condition |
| cmp_done | output | 1 | One-cycle completion pulse |
| rpt_count | output | 8 | Pending repeat count |
| acc_we | output | 1 | Accumulator write enable |
| mem_we | output | 1 | Memory write enable |

## Verification
The assertions assume that the accumulator and operand are stable and defined in any cycle where a compare issues, because the flag checks compare against their values one cycle earlier. They also assume that the strobes never carry unknown values after reset. The stimulus drives every input on the falling edge and holds it for a full cycle. It leaves data inputs at fixed known values when no compare is issued, and it never leaves the strobes undriven.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned INSTR_W   = 16;
    localparam int unsigned OPSEL_W   = 8;
    localparam int unsigned RPT_W     = 8;
    localparam logic [OPSEL_W-1:0] CMP_OPCODE = 8'h0F;

    // arithmetic result of one compare
    typedef struct packed {
        logic neg;
        logic zero;
        logic nobrw;
    } cmp_res_t;

    // architectural status bits held by the unit
    typedef struct packed {
        logic neg;
        logic zero;
        logic nobrw;
        logic ovf;
    } stat_t;

    localparam stat_t STAT_RESET = '{neg: 1'b0, zero: 1'b0, nobrw: 1'b0, ovf: 1'b0};

    // unsigned greater-than from no-borrow and zero
    function automatic logic higher_of(input cmp_res_t r);
        return r.nobrw & ~r.zero;
    endfunction

endpackage

// File: rtl/cmp_decode.sv
module cmp_decode
    import cmp_pkg::*;
#(
    parameter int unsigned SEL_W = OPSEL_W,
    parameter logic [SEL_W-1:0] MATCH = CMP_OPCODE
) (
    input  logic             issue_valid,
    input  logic [SEL_W-1:0] opc_sel,
    output logic             fire
);
    always_comb begin
        fire = issue_valid && (opc_sel == MATCH);
    end
endmodule

// File: rtl/cmp_diff.sv
module cmp_diff
    import cmp_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output cmp_res_t     res
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] diff_signed;
    logic [XW-1:0] diff_unsigned;

    always_comb begin
        // one extra bit makes the sign exact: no wrap possible
        diff_signed   = {lhs[W-1], lhs} - {rhs[W-1], rhs};
        diff_unsigned = {1'b0, lhs} - {1'b0, rhs};
        res.neg   = diff_signed[XW-1];
        res.zero  = ~|diff_unsigned[W-1:0];
        res.nobrw = ~diff_unsigned[XW-1];
    end
endmodule

// File: rtl/cmp_status.sv
module cmp_status
    import cmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  cmp_res_t res,
    input  logic     ovf_wr,
    input  logic     ovf_wdata,
    output stat_t    stat,
    output logic     higher,
    output logic     done
);
    localparam int unsigned NFLAG = 3;

    logic [NFLAG-1:0] res_bits;
    logic [NFLAG-1:0] flag_q;

    assign res_bits = {res.neg, res.zero, res.nobrw};

    genvar gi;
    generate
        for (gi = 0; gi < NFLAG; gi++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)       flag_q[gi] <= 1'b0;
                else if (fire) flag_q[gi] <= res_bits[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.ovf <= STAT_RESET.ovf;
            higher   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= fire;
            if (fire)   higher   <= higher_of(res);
            if (ovf_wr) stat.ovf <= ovf_wdata;
        end
    end

    always_comb begin
        stat.neg   = flag_q[2];
        stat.zero  = flag_q[1];
        stat.nobrw = flag_q[0];
    end

    // R7: no recognised compare, arithmetic flags hold
    a_r7_hold_flags: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(stat.neg) && $stable(stat.zero) && $stable(stat.nobrw) && $stable(higher));

    // R8: overflow untouched unless its own write strobe
    a_r8_ovf_keep: assert property (@(posedge clk) disable iff (rst)
        !ovf_wr |=> $stable(stat.ovf));

    // R6: completion pulse only follows an issue
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        fire |=> done);
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !done);
endmodule

// File: rtl/cmp_repeat.sv
module cmp_repeat
    import cmp_pkg::*;
#(
    parameter int unsigned W = RPT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (fire) count <= '0;
        else if (load) count <= value;
    end

    // R9: compare cancels any pending repeat, even a same-cycle load
    a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
        fire |=> count == '0);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !fire && !load |=> $stable(count));
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmp_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned IW  = INSTR_W,
    parameter int unsigned SW  = OPSEL_W,
    parameter int unsigned RW  = RPT_W,
    parameter logic [SW-1:0] OPC = CMP_OPCODE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic [IW-1:0] instr_word,
    input  logic [DW-1:0] acc_val,
    input  logic [DW-1:0] opnd_val,
    input  logic          ovf_wr,
    input  logic          ovf_wdata,
    input  logic          rpt_load,
    input  logic [RW-1:0] rpt_value,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v,
    output logic          cond_hi,
    output logic          cmp_done,
    output logic [RW-1:0] rpt_count,
    output logic          acc_we,
    output logic          mem_we
);
    localparam int unsigned SEL_LSB = IW - SW;

    logic     fire;
    cmp_res_t res;
    stat_t    stat;

    cmp_decode #(.SEL_W(SW), .MATCH(OPC)) u_decode (
        .issue_valid (issue_valid),
        .opc_sel     (instr_word[IW-1:SEL_LSB]),
        .fire        (fire)
    );

    cmp_diff #(.W(DW)) u_diff (
        .lhs (acc_val),
        .rhs (opnd_val),
        .res (res)
    );

    cmp_status u_status (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .res       (res),
        .ovf_wr    (ovf_wr),
        .ovf_wdata (ovf_wdata),
        .stat      (stat),
        .higher    (cond_hi),
        .done      (cmp_done)
    );

    cmp_repeat #(.W(RW)) u_repeat (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .load  (rpt_load),
        .value (rpt_value),
        .count (rpt_count)
    );

    assign flag_n = stat.neg;
    assign flag_z = stat.zero;
    assign flag_c = stat.nobrw;
    assign flag_v = stat.ovf;
    // compare produces flags only: no write path
    assign acc_we = 1'b0;
    assign mem_we = 1'b0;

    // R2: sign of the exact difference
    a_r2_exact_sign: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag_n == ($signed($past(acc_val)) < $signed($past(opnd_val))));

    // R3: equality
    a_r3_equal: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag_z == ($past(acc_val) == $past(opnd_val)));

    // R4: carry is no-borrow
    a_r4_no_borrow: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag_c == ($past(acc_val) >= $past(opnd_val)));

    // R5: higher is unsigned greater-than
    a_r5_higher: assert property (@(posedge clk) disable iff (rst)
        fire |=> cond_hi == ($past(acc_val) > $past(opnd_val)));
endmodule

// File: tb/tb_cmp_flag_unit.sv
module tb_cmp_flag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [15:0] instr_word;
    logic [31:0] acc_val, opnd_val;
    logic        ovf_wr, ovf_wdata, rpt_load;
    logic [7:0]  rpt_value;
    logic        flag_n, flag_z, flag_c, flag_v, cond_hi, cmp_done, acc_we, mem_we;
    logic [7:0]  rpt_count;

    always #5 clk = ~clk;

    cmp_flag_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr_word(instr_word),
        .acc_val(acc_val), .opnd_val(opnd_val), .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata),
        .rpt_load(rpt_load), .rpt_value(rpt_value), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v), .cond_hi(cond_hi), .cmp_done(cmp_done),
        .rpt_count(rpt_count), .acc_we(acc_we), .mem_we(mem_we)
    );

    typedef struct {
        logic       n, z, c, v, h, d;
        logic [7:0] rpt;
        string      tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    // reference state, from the requirements
    logic       m_n, m_z, m_c, m_v, m_h;
    logic [7:0] m_rpt;

    task automatic chk(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    // monitor: compares results against queued expectations
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R2", e.tag, flag_n, e.n);
            chk("R3", e.tag, flag_z, e.z);
            chk("R4", e.tag, flag_c, e.c);
            chk("R5", e.tag, cond_hi, e.h);
            chk("R6", e.tag, cmp_done, e.d);
            chk("R8", e.tag, flag_v, e.v);
            chk("R9", e.tag, rpt_count, e.rpt);
            chk("R10", e.tag, {acc_we, mem_we}, 2'b00);
        end
    end

    // driver: one cycle of stimulus, then the expectation for after the edge
    task automatic step(input string tag, input logic vld, input logic [15:0] w,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic rl, input logic [7:0] rv,
                        input logic vw, input logic vd);
        exp_t e;
        logic f;
        @(negedge clk);
        issue_valid = vld; instr_word = w; acc_val = a; opnd_val = b;
        rpt_load = rl; rpt_value = rv; ovf_wr = vw; ovf_wdata = vd;
        f = vld && (w[15:8] == 8'h0F);           // R1 recognition
        if (f) begin
            m_n = $signed(a) < $signed(b);
            m_z = (a == b);
            m_c = (a >= b);
            m_h = (a > b);
            m_rpt = 8'd0;
        end else if (rl) begin
            m_rpt = rv;
        end
        if (vw) m_v = vd;
        e.n = m_n; e.z = m_z; e.c = m_c; e.v = m_v; e.h = m_h; e.d = f;
        e.rpt = m_rpt; e.tag = tag;
        @(posedge clk);
        #1 q.push_back(e);
    endtask

    task automatic cmp(input string tag, input logic [7:0] mode, input logic [31:0] a, input logic [31:0] b);
        step(tag, 1'b1, {8'h0F, mode}, a, b, 1'b0, 8'd0, 1'b0, 1'b0);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 16'h0000, 32'd0, 32'd0, 1'b0, 8'd0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        rst = 1'b1; issue_valid = 0; instr_word = 0; acc_val = 0; opnd_val = 0;
        ovf_wr = 0; ovf_wdata = 0; rpt_load = 0; rpt_value = 0;
        m_n = 0; m_z = 0; m_c = 0; m_v = 0; m_h = 0; m_rpt = 0;
        // set state before reset to prove R11 clears it
        repeat (2) @(negedge clk);
        ovf_wr = 1; ovf_wdata = 1; rpt_load = 1; rpt_value = 8'h33;
        issue_valid = 1; instr_word = 16'h0F00; acc_val = 5; opnd_val = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        issue_valid = 0; ovf_wr = 0; rpt_load = 0;
        idle("R11 reset state");

        cmp("R3 equal", 8'h00, 32'h1234_5678, 32'h1234_5678);
        cmp("R4 acc above", 8'h00, 32'h0000_0010, 32'h0000_0003);
        cmp("R4 acc below", 8'h00, 32'h0000_0003, 32'h0000_0010);
        cmp("R2 exact sign 8000_0000-1", 8'h00, 32'h8000_0000, 32'h0000_0001);
        cmp("R2 exact sign 7FFF_FFFF-FFFF_FFFF", 8'h00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        cmp("R2 negative minus positive", 8'h00, 32'hFFFF_FFFE, 32'h0000_0002);
        cmp("R5 zero vs max", 8'h00, 32'h0000_0000, 32'hFFFF_FFFF);
        cmp("R1 mode byte A5", 8'hA5, 32'h0000_0009, 32'h0000_0009);
        cmp("R1 mode byte FF", 8'hFF, 32'h8000_0000, 32'h7FFF_FFFF);

        // R7: not a compare, flags must hold
        step("R7 R1 wrong opcode", 1'b1, 16'h1F00, 32'd1, 32'd7, 1'b0, 8'd0, 1'b0, 1'b0);
        step("R7 R1 upper nibble", 1'b1, 16'h0E0F, 32'd1, 32'd7, 1'b0, 8'd0, 1'b0, 1'b0);
        step("R7 valid low", 1'b0, 16'h0F00, 32'd7, 32'd7, 1'b0, 8'd0, 1'b0, 1'b0);

        // R8: overflow path and compare independence
        step("R8 set ovf", 1'b0, 16'h0000, 32'd0, 32'd0, 1'b0, 8'd0, 1'b1, 1'b1);
        cmp("R8 compare keeps ovf", 8'h00, 32'h8000_0000, 32'h0000_0001);
        step("R8 write during compare", 1'b1, 16'h0F00, 32'd4, 32'd4, 1'b0, 8'd0, 1'b1, 1'b0);

        // R9: repeat counter
        step("R9 load", 1'b0, 16'h0000, 32'd0, 32'd0, 1'b1, 8'h2A, 1'b0, 1'b0);
        idle("R9 hold");
        cmp("R9 cancel", 8'h10, 32'd3, 32'd3);
        step("R9 load again", 1'b0, 16'h0000, 32'd0, 32'd0, 1'b1, 8'hFF, 1'b0, 1'b0);
        step("R9 compare wins over load", 1'b1, 16'h0F22, 32'd9, 32'd2, 1'b1, 8'h11, 1'b0, 1'b0);
        step("R9 load with wrong opcode", 1'b1, 16'h0100, 32'd0, 32'd5, 1'b1, 8'h07, 1'b0, 1'b0);

        // R6: back-to-back compares each complete in one cycle
        for (int i = 0; i < 48; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 6 == 0) ? a : $urandom;
            if (i % 5 == 1) b = a + 32'd1;
            if (i % 5 == 2) b = a ^ 32'h8000_0000;
            cmp("R6 back-to-back", i[7:0], a, b);
        end
        idle("R6 done drops");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule